// File: doc/BRIEF.md
# Calendar Time-Stamp Capture Unit

This block records the running calendar when a time-stamp event happens. The event can come from an external pin, from an internal event raised when the supply moves to the battery domain, or from a tamper detector. On the first event it copies the live sub-second, time and date values into three snapshot registers. It then reports the capture through a flag that waits for the input synchronizer: the flag rises on the second prescaler tick after the event.

Further events that arrive while a capture is pending or already flagged do not touch the snapshot. They set an overflow flag at once. Software clears the flags by writing zeros through a small clear port, and an optional interrupt follows the capture flag. The calendar counter, the prescaler and the register bus sit outside this block.

Top module: `ts_capture_unit`

## Requirements
- R1: On an accepted event, meaning any enabled source while neither a capture is pending nor the capture flag is set, the sub-second, time and date inputs sampled at that clock edge appear on the snapshot outputs after the edge.
- R2: The external pin passes through two synchronizer flops and a rising-edge detector. A rise that is sampled at edge k counts as an event at edge k+2, and only when the pin enable is 1. Each rise gives one event, however long the pin stays high.
- R3: A battery-switch event counts only while the internal-stamp enable is 1. When it causes the capture, the internal flag rises together with the capture flag.
- R4: A tamper event counts only while the tamper-to-stamp enable is 1. It sets only the capture flag.
- R5: The capture flag rises at the clock edge that samples the second tick after the accepting edge. A tick sampled at the accepting edge itself is not counted.
- R6: An event at an edge where a capture is pending or the capture flag is set makes the overflow flag 1 after that same edge. The snapshot outputs keep the earlier values.
- R7: clr_data_i bit 0 is the capture flag, bit 1 the internal flag and bit 2 the overflow flag. With clr_we_i at 1, a 0 in a bit clears that flag and a 1 leaves it unchanged.
- R8: If a clear of the capture flag and an event fall on the same edge, the capture flag stays 1 and the overflow flag becomes 1.
- R9: The interrupt output is 1 exactly when the capture flag and the interrupt enable are both 1.
- R10: After reset all flags, the interrupt and the snapshot outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Prescaler clock-enable tick |
| cal_subsec_i | input | SS_W | Live sub-second count |
| cal_time_i | input | TIME_W | Live time of day |
| cal_date_i | input | DATE_W | Live date |
| stamp_pin_i | input | 1 | External event pin (asynchronous) |
| pin_en_i | input | 1 | Enables the pin as a source |
| vbat_evt_i | input | 1 | One-cycle pulse on switch to battery supply |
| int_stamp_en_i | input | 1 | Enables the battery-switch source |
| tamper_evt_i | input | 1 | One-cycle tamper event pulse |
| tamper_stamp_en_i | input | 1 | Enables the tamper source |
| irq_en_i | input | 1 | Interrupt enable |
| clr_we_i | input | 1 | Flag clear strobe |
| clr_data_i | input | 3 | Clear mask, write 0 to clear |
| snap_subsec_o | output | SS_W | Captured sub-second |
| snap_time_o | output | TIME_W | Captured time |
| snap_date_o | output | DATE_W | Captured date |
| flag_cap_o | output | 1 | Capture flag |
| flag_int_o | output | 1 | Internal-source capture flag |
| flag_ovf_o | output | 1 | Overflow flag |
| irq_o | output | 1 | Interrupt |

## Verification
The bench fires a second event inside the two-tick window, before the capture flag shows. A design that keys overflow off the visible flag alone would then miss the overflow and overwrite the snapshot. It also lines up a zero-write clear with a new event on the same edge; a design where the clear wins would drop the capture flag and lose the event. Ticks that land on the accepting edge itself catch a counter that sets the flag one tick early. A long-held pin catches an edge detector that fires on the level rather than the rise.

// File: rtl/ts_cap_pkg.sv
package ts_cap_pkg;
  localparam int CLR_CAP_BIT = 0;
  localparam int CLR_INT_BIT = 1;
  localparam int CLR_OVF_BIT = 2;
  localparam int CLR_W       = 3;

  function automatic logic f_rise(input logic cur, input logic prev);
    return cur & ~prev;
  endfunction

  function automatic logic f_clear_hit(input logic we, input logic mask_bit);
    return we & ~mask_bit;
  endfunction

  function automatic logic f_last_tick(input int unsigned cnt, input int unsigned lim);
    return cnt == (lim - 1);
  endfunction
endpackage

// File: rtl/ts_pin_sync.sv
module ts_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic rise_o
);
  import ts_cap_pkg::*;

  logic [STAGES:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-1:0], pin_i};
  end

  assign rise_o = f_rise(chain[STAGES-1], chain[STAGES]);

  assert_single_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
endmodule

// File: rtl/ts_source_qual.sv
module ts_source_qual #(
  parameter int NSRC = 3
) (
  input  logic [NSRC-1:0] src_i,
  input  logic [NSRC-1:0] en_i,
  input  logic [NSRC-1:0] internal_mask_i,
  output logic            evt_o,
  output logic            evt_int_o
);
  logic [NSRC-1:0] live;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    assign live[g] = src_i[g] & en_i[g];
  end

  assign evt_o     = |live;
  assign evt_int_o = |(live & internal_mask_i);
endmodule

// File: rtl/ts_flag_ctrl.sv
module ts_flag_ctrl #(
  parameter int SYNC_TICKS = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       evt_i,
  input  logic       evt_int_i,
  input  logic       tick_i,
  input  logic       clr_we_i,
  input  logic [2:0] clr_data_i,
  output logic       snap_we_o,
  output logic       flag_cap_o,
  output logic       flag_int_o,
  output logic       flag_ovf_o
);
  import ts_cap_pkg::*;

  localparam int CNT_W = $clog2(SYNC_TICKS + 1);

  logic             pend, pend_int;
  logic [CNT_W-1:0] cnt;
  logic             busy, done_evt, ovf_evt;
  logic             clr_cap, clr_int, clr_ovf;

  assign busy     = flag_cap_o | pend;
  assign snap_we_o = evt_i & ~busy;
  assign ovf_evt  = evt_i & busy;
  assign done_evt = pend & tick_i & f_last_tick(int'(cnt), SYNC_TICKS);
  assign clr_cap  = f_clear_hit(clr_we_i, clr_data_i[CLR_CAP_BIT]);
  assign clr_int  = f_clear_hit(clr_we_i, clr_data_i[CLR_INT_BIT]);
  assign clr_ovf  = f_clear_hit(clr_we_i, clr_data_i[CLR_OVF_BIT]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 1'b0; pend_int <= 1'b0; cnt <= '0;
    end else if (snap_we_o) begin
      pend <= 1'b1; pend_int <= evt_int_i; cnt <= '0;
    end else if (pend && tick_i) begin
      if (done_evt) begin
        pend <= 1'b0; cnt <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_cap_o <= 1'b0; flag_int_o <= 1'b0; flag_ovf_o <= 1'b0;
    end else begin
      if (done_evt)                flag_cap_o <= 1'b1;
      else if (clr_cap && !evt_i)  flag_cap_o <= 1'b0;
      if (done_evt && pend_int)    flag_int_o <= 1'b1;
      else if (clr_int)            flag_int_o <= 1'b0;
      if (ovf_evt)                 flag_ovf_o <= 1'b1;
      else if (clr_ovf)            flag_ovf_o <= 1'b0;
    end
  end

  assert_ovf_on_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i && busy) |=> flag_ovf_o);
  assert_flag_after_wait_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_cap_o) |-> ($past(pend) && $past(tick_i)));
  assert_collision_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_cap_o && evt_i) |=> (flag_cap_o && flag_ovf_o));
  assert_int_with_cap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_int_o) |-> flag_cap_o);
endmodule

// File: rtl/ts_snap_regs.sv
module ts_snap_regs #(
  parameter int SS_W   = 16,
  parameter int TIME_W = 22,
  parameter int DATE_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [SS_W-1:0]   ss_i,
  input  logic [TIME_W-1:0] time_i,
  input  logic [DATE_W-1:0] date_i,
  output logic [SS_W-1:0]   ss_o,
  output logic [TIME_W-1:0] time_o,
  output logic [DATE_W-1:0] date_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ss_o <= '0; time_o <= '0; date_o <= '0;
    end else if (we_i) begin
      ss_o <= ss_i; time_o <= time_i; date_o <= date_i;
    end
  end

  assert_hold_when_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !we_i |=> ($stable(ss_o) && $stable(time_o) && $stable(date_o)));
  assert_load_on_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |=> (time_o == $past(time_i) && date_o == $past(date_i)));
endmodule

// File: rtl/ts_capture_unit.sv
module ts_capture_unit #(
  parameter int SS_W        = 16,
  parameter int TIME_W      = 22,
  parameter int DATE_W      = 24,
  parameter int SYNC_STAGES = 2,
  parameter int SYNC_TICKS  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic [SS_W-1:0]   cal_subsec_i,
  input  logic [TIME_W-1:0] cal_time_i,
  input  logic [DATE_W-1:0] cal_date_i,
  input  logic              stamp_pin_i,
  input  logic              pin_en_i,
  input  logic              vbat_evt_i,
  input  logic              int_stamp_en_i,
  input  logic              tamper_evt_i,
  input  logic              tamper_stamp_en_i,
  input  logic              irq_en_i,
  input  logic              clr_we_i,
  input  logic [2:0]        clr_data_i,
  output logic [SS_W-1:0]   snap_subsec_o,
  output logic [TIME_W-1:0] snap_time_o,
  output logic [DATE_W-1:0] snap_date_o,
  output logic              flag_cap_o,
  output logic              flag_int_o,
  output logic              flag_ovf_o,
  output logic              irq_o
);
  localparam int NSRC = 3;

  logic pin_rise;
  logic evt_any, evt_int;
  logic snap_we;

  ts_pin_sync #(.STAGES(SYNC_STAGES)) u_pin (
    .clk(clk), .rst_n(rst_n), .pin_i(stamp_pin_i), .rise_o(pin_rise)
  );

  ts_source_qual #(.NSRC(NSRC)) u_qual (
    .src_i({tamper_evt_i, vbat_evt_i, pin_rise}),
    .en_i({tamper_stamp_en_i, int_stamp_en_i, pin_en_i}),
    .internal_mask_i(3'b010),
    .evt_o(evt_any),
    .evt_int_o(evt_int)
  );

  ts_flag_ctrl #(.SYNC_TICKS(SYNC_TICKS)) u_flags (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_any), .evt_int_i(evt_int),
    .tick_i(tick_i), .clr_we_i(clr_we_i), .clr_data_i(clr_data_i),
    .snap_we_o(snap_we), .flag_cap_o(flag_cap_o), .flag_int_o(flag_int_o),
    .flag_ovf_o(flag_ovf_o)
  );

  ts_snap_regs #(.SS_W(SS_W), .TIME_W(TIME_W), .DATE_W(DATE_W)) u_snap (
    .clk(clk), .rst_n(rst_n), .we_i(snap_we),
    .ss_i(cal_subsec_i), .time_i(cal_time_i), .date_i(cal_date_i),
    .ss_o(snap_subsec_o), .time_o(snap_time_o), .date_o(snap_date_o)
  );

  assign irq_o = flag_cap_o & irq_en_i;

  assert_irq_follows_en_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_en_i |-> !irq_o));
endmodule

// File: tb/test_ts_capture_unit.sv
module test_ts_capture_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic [15:0] cal_ss = '0;
  logic [21:0] cal_tm = '0;
  logic [23:0] cal_dt = '0;
  logic pin = 1'b0, pin_en = 1'b0, vbat = 1'b0, int_en = 1'b0;
  logic tamp = 1'b0, tamp_en = 1'b0, irq_en = 1'b0, clr_we = 1'b0;
  logic [2:0] clr_data = 3'b111;
  logic [15:0] s_ss; logic [21:0] s_tm; logic [23:0] s_dt;
  logic f_cap, f_int, f_ovf, irq;

  always #10 clk = ~clk;

  ts_capture_unit i_ts_capture_unit (
    .clk(clk), .rst_n(rst_n), .tick_i(tick),
    .cal_subsec_i(cal_ss), .cal_time_i(cal_tm), .cal_date_i(cal_dt),
    .stamp_pin_i(pin), .pin_en_i(pin_en), .vbat_evt_i(vbat),
    .int_stamp_en_i(int_en), .tamper_evt_i(tamp), .tamper_stamp_en_i(tamp_en),
    .irq_en_i(irq_en), .clr_we_i(clr_we), .clr_data_i(clr_data),
    .snap_subsec_o(s_ss), .snap_time_o(s_tm), .snap_date_o(s_dt),
    .flag_cap_o(f_cap), .flag_int_o(f_int), .flag_ovf_o(f_ovf), .irq_o(irq)
  );

  int vectors = 0, miscompares = 0;
  string cur_req = "R10";
  bit finished = 0;
  int cal_cnt = 0;

  // behavioural reference
  bit pin_hist[$] = '{0, 0, 0};
  int m_ss = 0, m_tm = 0, m_dt = 0;
  bit m_cap = 0, m_int = 0, m_ovf = 0, m_pend = 0, m_pend_int = 0;
  int m_ticks = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      pin_hist = '{0, 0, 0};
      m_ss = 0; m_tm = 0; m_dt = 0;
      m_cap = 0; m_int = 0; m_ovf = 0; m_pend = 0; m_pend_int = 0; m_ticks = 0;
    end else begin
      bit ext_rise, ev, ev_int, busy, done;
      bit n_cap, n_int, n_ovf;
      ext_rise = pin_hist[1] && !pin_hist[2];
      ev = (ext_rise && pin_en) || (vbat && int_en) || (tamp && tamp_en);
      ev_int = vbat && int_en;
      busy = m_cap || m_pend;
      done = m_pend && tick && (m_ticks + 1 == 2);
      n_cap = m_cap; n_int = m_int; n_ovf = m_ovf;
      if (done) n_cap = 1;
      else if (clr_we && !clr_data[0] && !ev) n_cap = 0;
      if (done && m_pend_int) n_int = 1;
      else if (clr_we && !clr_data[1]) n_int = 0;
      if (ev && busy) n_ovf = 1;
      else if (clr_we && !clr_data[2]) n_ovf = 0;
      if (ev && !busy) begin
        m_ss = cal_ss; m_tm = cal_tm; m_dt = cal_dt;
        m_pend = 1; m_pend_int = ev_int; m_ticks = 0;
      end else if (m_pend && tick) begin
        if (done) begin m_pend = 0; m_ticks = 0; end
        else m_ticks = m_ticks + 1;
      end
      m_cap = n_cap; m_int = n_int; m_ovf = n_ovf;
      pin_hist.push_front(pin);
      void'(pin_hist.pop_back());
    end
  end

  task automatic chk(string fld, longint act, longint exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%0h expected=%0h", cur_req, fld, act, exp);
    end
  endtask

  task automatic compare();
    chk("snap_subsec", s_ss, m_ss);
    chk("snap_time", s_tm, m_tm);
    chk("snap_date", s_dt, m_dt);
    chk("flag_cap", f_cap, m_cap);
    chk("flag_int", f_int, m_int);
    chk("flag_ovf", f_ovf, m_ovf);
    chk("irq", irq, m_cap && irq_en);
  endtask

  task automatic step(int tick_rate = 3);
    @(negedge clk);
    compare();
    cal_cnt++;
    cal_ss = 16'(cal_cnt * 7);
    cal_tm = 22'(cal_cnt * 3 + 5);
    cal_dt = 24'(cal_cnt >> 2);
    tick = ($urandom_range(0, tick_rate - 1) == 0);
    vbat = 0; tamp = 0; clr_we = 0; clr_data = 3'b111;
  endtask

  task automatic clear_all();
    clr_we = 1; clr_data = 3'b000;
    step();
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    // R10: reset values
    cur_req = "R10";
    repeat (3) step();
    @(negedge clk); rst_n = 1;
    step();

    // R2 + R5 + R1: pin rise held long, one capture only
    cur_req = "R2"; pin_en = 1;
    step(); pin = 1;
    repeat (12) step();
    cur_req = "R5";
    repeat (12) step();
    pin = 0;
    repeat (4) step();

    // R7: write ones keeps flags, zero clears capture flag
    cur_req = "R7";
    clr_we = 1; clr_data = 3'b111; step(); step();
    clr_we = 1; clr_data = 3'b110; step(); step();

    // R2: pin enable off, rise ignored
    cur_req = "R2"; pin_en = 0; pin = 1;
    repeat (10) step();
    pin = 0; step();

    // R3: internal source gated, then accepted
    cur_req = "R3"; int_en = 0;
    vbat = 1; repeat (10) step();
    int_en = 1; step(); vbat = 1;
    repeat (14) step();
    clear_all(); step();

    // R4: tamper gated, then accepted
    cur_req = "R4"; tamp_en = 0;
    tamp = 1; repeat (10) step();
    tamp_en = 1; step(); tamp = 1;
    repeat (14) step();
    clear_all(); step();

    // R6: second event inside the wait window, tick held low
    cur_req = "R6";
    tamp = 1; step(1000); tamp = 1; step(1000); tick = 0;
    step(1000);
    repeat (12) step();
    tamp = 1; step();
    repeat (3) step();
    clear_all(); step();

    // R8: clear colliding with a new event
    cur_req = "R8";
    tamp = 1; repeat (14) step();
    clr_we = 1; clr_data = 3'b110; tamp = 1; step();
    repeat (3) step();
    clear_all(); step();

    // R9: interrupt enable toggling with flag set and clear
    cur_req = "R9";
    irq_en = 1; tamp = 1; repeat (14) step();
    irq_en = 0; step(); irq_en = 1; step();
    clear_all(); repeat (2) step();

    // R1: mixed random traffic
    cur_req = "R1";
    for (int i = 0; i < 3000; i++) begin
      step();
      if ($urandom_range(0, 9) == 0) pin = ~pin;
      vbat = ($urandom_range(0, 19) == 0);
      tamp = ($urandom_range(0, 24) == 0);
      if ($urandom_range(0, 14) == 0) begin
        clr_we = 1; clr_data = 3'($urandom_range(0, 7));
      end
      if ($urandom_range(0, 49) == 0) begin
        pin_en = 1'($urandom); int_en = 1'($urandom);
        tamp_en = 1'($urandom); irq_en = 1'($urandom);
      end
    end
    step();

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule